// File: doc/BRIEF.md
# Indirect-Access Shared Mailbox RAM

Two processors share one 256-word by 8-bit memory. Neither processor drives a memory address. Each side has its own small window of four registers, selected by a 2-bit index. One register holds an address pointer for that side. A data register reads or writes the array at that pointer. Two further registers let each processor leave a one-byte message for the other and collect the message the other side left.

Each side presents a request, a direction and a register index, and holds them until its `ready` output is high in that cycle. The request completes at the next rising clock edge. When both sides reach for the array in the same cycle, an internal round-robin arbiter lets one through. It holds the other side's `ready` low for exactly one cycle, then serves it. A per-side message-pending output signals that a fresh message is waiting.

Top module: `dual_mailbox_ram`

## Requirements
- R1: A write to register index 1 stores the write data in the array at the side's pointer. A later read of index 1 at that pointer returns it, whichever side wrote it.
- R2: Register index 0 is the side's address pointer. A write loads it from the write data and a read returns it zero-extended. Index 2 is the outgoing message and index 3 is the incoming message.
- R3: Every completed access to index 1 advances that side's pointer by one, and the pointer wraps from 255 to 0.
- R4: A write to index 2 on one side raises the other side's message-pending output from the next cycle. That side then reads the written byte at index 3.
- R5: A read of index 3 clears that side's message-pending output from the next cycle. If the other side posts a message in the same cycle, the flag stays set.
- R6: A read of index 2 returns the last message that side itself posted.
- R7: `ready` is high while a side is idle or accesses indices 0, 2 or 3. A lone access to index 1 also has `ready` high in the same cycle.
- R8: When both sides request index 1 in one cycle, exactly one has `ready` high. The other has `ready` low for that one cycle only and completes in the next cycle.
- R9: The first contention after reset goes to side A. After every contended cycle, the side that lost holds priority for the next contention.
- R10: Reset clears both pointers, both outgoing messages and both pending flags. The array contents are left untouched.
- R11: The read data output is zero in any cycle that is not a completing read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_req | input | 1 | Side A request |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_idx | input | 2 | Side A register index |
| a_wdata | input | 8 | Side A write data |
| a_rdata | output | 8 | Side A read data |
| a_ready | output | 1 | Side A access completes this cycle / not stalled |
| a_msg_pend | output | 1 | Side A has an unread incoming message |
| b_req | input | 1 | Side B request |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_idx | input | 2 | Side B register index |
| b_wdata | input | 8 | Side B write data |
| b_rdata | output | 8 | Side B read data |
| b_ready | output | 1 | Side B access completes this cycle / not stalled |
| b_msg_pend | output | 1 | Side B has an unread incoming message |

## Verification
The one-cycle stall properties assume that a stalled side either keeps its index-1 request asserted into the next cycle or drops it. The arbiter state then always points at the waiting side. The message properties assume that a side never posts and reads its own incoming register in the same cycle, and this holds because each side issues one request per cycle. The stimulus re-presents every stalled request unchanged and draws fresh random requests only for sides that completed. Array reads are made only after the whole array has been written, so every read value is defined.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [1:0] {
        REG_PTR  = 2'd0,
        REG_DATA = 2'd1,
        REG_OUT  = 2'd2,
        REG_IN   = 2'd3
    } mbx_reg_e;

    localparam int NUM_SIDES = 2;

endpackage

// File: rtl/mbx_arbiter.sv
module mbx_arbiter #(
    parameter int NS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NS-1:0] want_i,
    output logic [NS-1:0] grant_o
);
    typedef struct packed {
        logic prio;
    } arb_state_t;

    arb_state_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        grant_o = want_i;
        if (&want_i) begin
            grant_o = '0;
            grant_o[st_q.prio] = 1'b1;
            st_d.prio = ~st_q.prio;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/mbx_array.sv
module mbx_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) mem_q[addr_i] <= wdata_i;
    end

    assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/mbx_side.sv
module mbx_side
    import mbx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic          wr_i,
    input  logic [1:0]    idx_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          grant_i,
    input  logic          peer_post_i,
    input  logic [DW-1:0] peer_msg_i,
    input  logic [DW-1:0] arr_rdata_i,
    output logic          ready_o,
    output logic [DW-1:0] rdata_o,
    output logic          arr_req_o,
    output logic          arr_we_o,
    output logic [AW-1:0] ptr_o,
    output logic [DW-1:0] out_msg_o,
    output logic          post_o,
    output logic          pend_o
);
    typedef struct packed {
        logic [AW-1:0] ptr;
        logic [DW-1:0] outm;
        logic          pend;
    } side_state_t;

    side_state_t st_q, st_d;
    mbx_reg_e    sel;
    logic        done_arr;
    logic        rd_in;

    assign sel = mbx_reg_e'(idx_i);

    always_comb begin
        st_d      = st_q;
        arr_req_o = req_i && (sel == REG_DATA);
        arr_we_o  = arr_req_o && wr_i;
        done_arr  = arr_req_o && grant_i;
        ready_o   = !arr_req_o || grant_i;
        post_o    = req_i && wr_i && (sel == REG_OUT);
        rd_in     = req_i && !wr_i && (sel == REG_IN);

        rdata_o = '0;
        if (req_i && !wr_i && ready_o) begin
            unique case (sel)
                REG_PTR:  rdata_o = DW'(st_q.ptr);
                REG_DATA: rdata_o = arr_rdata_i;
                REG_OUT:  rdata_o = st_q.outm;
                REG_IN:   rdata_o = peer_msg_i;
                default:  rdata_o = '0;
            endcase
        end

        if (req_i && wr_i && (sel == REG_PTR)) st_d.ptr = wdata_i[AW-1:0];
        else if (done_arr)                     st_d.ptr = st_q.ptr + 1'b1;

        if (post_o) st_d.outm = wdata_i;

        if (peer_post_i) st_d.pend = 1'b1;
        else if (rd_in)  st_d.pend = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ptr_o     = st_q.ptr;
    assign out_msg_o = st_q.outm;
    assign pend_o    = st_q.pend;
endmodule

// File: rtl/dual_mailbox_ram.sv
module dual_mailbox_ram
    import mbx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_req,
    input  logic          a_wr,
    input  logic [1:0]    a_idx,
    input  logic [DW-1:0] a_wdata,
    output logic [DW-1:0] a_rdata,
    output logic          a_ready,
    output logic          a_msg_pend,
    input  logic          b_req,
    input  logic          b_wr,
    input  logic [1:0]    b_idx,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata,
    output logic          b_ready,
    output logic          b_msg_pend
);
    localparam int NS = NUM_SIDES;

    logic                req   [NS];
    logic                wr    [NS];
    logic [1:0]          idx   [NS];
    logic [DW-1:0]       wd    [NS];
    logic [DW-1:0]       rd    [NS];
    logic                rdy   [NS];
    logic                pend  [NS];
    logic [AW-1:0]       ptr   [NS];
    logic [DW-1:0]       outm  [NS];
    logic [NS-1:0]       want, grant, we_req, post;

    logic                arr_we;
    logic [AW-1:0]       arr_addr;
    logic [DW-1:0]       arr_wdata, arr_rdata;
    logic [AW-1:0]       ptr_a, ptr_b;

    assign req[0] = a_req;  assign wr[0] = a_wr;  assign idx[0] = a_idx;  assign wd[0] = a_wdata;
    assign req[1] = b_req;  assign wr[1] = b_wr;  assign idx[1] = b_idx;  assign wd[1] = b_wdata;
    assign a_rdata = rd[0]; assign a_ready = rdy[0]; assign a_msg_pend = pend[0];
    assign b_rdata = rd[1]; assign b_ready = rdy[1]; assign b_msg_pend = pend[1];
    assign ptr_a = ptr[0];
    assign ptr_b = ptr[1];

    for (genvar s = 0; s < NS; s++) begin : g_side
        localparam int P = NS - 1 - s;
        mbx_side #(.AW(AW), .DW(DW)) u_side (
            .clk         (clk),
            .rst         (rst),
            .req_i       (req[s]),
            .wr_i        (wr[s]),
            .idx_i       (idx[s]),
            .wdata_i     (wd[s]),
            .grant_i     (grant[s]),
            .peer_post_i (post[P]),
            .peer_msg_i  (outm[P]),
            .arr_rdata_i (arr_rdata),
            .ready_o     (rdy[s]),
            .rdata_o     (rd[s]),
            .arr_req_o   (want[s]),
            .arr_we_o    (we_req[s]),
            .ptr_o       (ptr[s]),
            .out_msg_o   (outm[s]),
            .post_o      (post[s]),
            .pend_o      (pend[s])
        );
    end

    mbx_arbiter #(.NS(NS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .want_i  (want),
        .grant_o (grant)
    );

    always_comb begin
        arr_we    = 1'b0;
        arr_addr  = ptr[0];
        arr_wdata = wd[0];
        for (int k = 0; k < NS; k++) begin
            if (grant[k]) begin
                arr_we    = we_req[k];
                arr_addr  = ptr[k];
                arr_wdata = wd[k];
            end
        end
    end

    mbx_array #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .we_i    (arr_we),
        .addr_i  (arr_addr),
        .wdata_i (arr_wdata),
        .rdata_o (arr_rdata)
    );
endmodule

// File: rtl/mbx_checker.sv
module mbx_checker #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          a_req,
    input logic          a_wr,
    input logic [1:0]    a_idx,
    input logic          a_ready,
    input logic          a_msg_pend,
    input logic          b_req,
    input logic          b_wr,
    input logic [1:0]    b_idx,
    input logic          b_ready,
    input logic          b_msg_pend,
    input logic [AW-1:0] ptr_a,
    input logic [AW-1:0] ptr_b
);
    AST_NO_DOUBLE_STALL: assert property (@(posedge clk) disable iff (rst) !(!a_ready && !b_ready)); // R8
    AST_A_STALL_ONE: assert property (@(posedge clk) disable iff (rst) !a_ready |=> a_ready); // R8
    AST_B_STALL_ONE: assert property (@(posedge clk) disable iff (rst) !b_ready |=> b_ready); // R8
    AST_A_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (a_req && a_idx == 2'd1 && a_ready) |=> ptr_a == AW'($past(ptr_a) + 1'b1)); // R3
    AST_B_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        (b_req && b_idx == 2'd1 && b_ready) |=> ptr_b == AW'($past(ptr_b) + 1'b1)); // R3
    AST_A_POST_FLAGS_B: assert property (@(posedge clk) disable iff (rst)
        (a_req && a_wr && a_idx == 2'd2) |=> b_msg_pend); // R4
    AST_B_POST_FLAGS_A: assert property (@(posedge clk) disable iff (rst)
        (b_req && b_wr && b_idx == 2'd2) |=> a_msg_pend); // R4
    AST_A_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (a_req && !a_wr && a_idx == 2'd3 && !(b_req && b_wr && b_idx == 2'd2)) |=> !a_msg_pend); // R5
    AST_B_TAKE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (b_req && !b_wr && b_idx == 2'd3 && !(a_req && a_wr && a_idx == 2'd2)) |=> !b_msg_pend); // R5
    AST_IDLE_READY: assert property (@(posedge clk) disable iff (rst)
        (!a_req || a_idx != 2'd1) |-> a_ready); // R7
endmodule

bind dual_mailbox_ram mbx_checker #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .a_req      (a_req),
    .a_wr       (a_wr),
    .a_idx      (a_idx),
    .a_ready    (a_ready),
    .a_msg_pend (a_msg_pend),
    .b_req      (b_req),
    .b_wr       (b_wr),
    .b_idx      (b_idx),
    .b_ready    (b_ready),
    .b_msg_pend (b_msg_pend),
    .ptr_a      (ptr_a),
    .ptr_b      (ptr_b)
);

// File: tb/tb_dual_mailbox_ram.sv
`timescale 1ns/1ps
module tb_dual_mailbox_ram;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rq [2];
    logic       wr [2];
    logic [1:0] ix [2];
    logic [7:0] wd [2];
    logic [7:0] rdd [2];
    logic       rdy [2];
    logic       pnd [2];

    int total = 0;
    int fails = 0;
    int mmem [256];
    int mptr [2];
    int mout [2];
    int mpend [2];
    int mprio;

    always #10 clk = ~clk;

    dual_mailbox_ram dut (
        .clk(clk), .rst(rst),
        .a_req(rq[0]), .a_wr(wr[0]), .a_idx(ix[0]), .a_wdata(wd[0]),
        .a_rdata(rdd[0]), .a_ready(rdy[0]), .a_msg_pend(pnd[0]),
        .b_req(rq[1]), .b_wr(wr[1]), .b_idx(ix[1]), .b_wdata(wd[1]),
        .b_rdata(rdd[1]), .b_ready(rdy[1]), .b_msg_pend(pnd[1])
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // behavioural reference, compared every cycle
    always @(negedge clk) begin : model
        int ar [2];
        int g [2];
        int er, erd, np, post [2];
        string tag;
        if (rst) begin
            for (int s = 0; s < 2; s++) begin
                mptr[s] = 0; mout[s] = 0; mpend[s] = 0;
            end
            mprio = 0;
        end else begin
            for (int s = 0; s < 2; s++) ar[s] = (rq[s] && ix[s] == 2'd1) ? 1 : 0;
            if (ar[0] == 1 && ar[1] == 1) begin
                g[mprio] = 1; g[1-mprio] = 0;
            end else begin
                g[0] = ar[0]; g[1] = ar[1];
            end
            for (int s = 0; s < 2; s++) begin
                er  = (ar[s] == 0 || g[s] == 1) ? 1 : 0;
                chk("R8 ready", int'(rdy[s]), er);
                erd = 0;
                tag = "R11 rdata idle";
                if (rq[s] && !wr[s] && er == 1) begin
                    case (ix[s])
                        2'd0: begin erd = mptr[s];      tag = "R2 ptr read"; end
                        2'd1: begin erd = mmem[mptr[s]]; tag = "R1 data read"; end
                        2'd2: begin erd = mout[s];      tag = "R6 out read"; end
                        default: begin erd = mout[1-s]; tag = "R4 in read"; end
                    endcase
                end
                chk(tag, int'(rdd[s]), erd);
                chk("R5 pend", int'(pnd[s]), mpend[s]);
            end
            for (int s = 0; s < 2; s++) post[s] = (rq[s] && wr[s] && ix[s] == 2'd2) ? 1 : 0;
            for (int s = 0; s < 2; s++) begin
                if (post[1-s] == 1) mpend[s] = 1;
                else if (rq[s] && !wr[s] && ix[s] == 2'd3) mpend[s] = 0;
                if (post[s] == 1) mout[s] = int'(wd[s]);
                np = mptr[s];
                if (rq[s] && wr[s] && ix[s] == 2'd0) np = int'(wd[s]);
                else if (g[s] == 1) np = (mptr[s] + 1) % 256;
                if (g[s] == 1 && wr[s]) mmem[mptr[s]] = int'(wd[s]);
                mptr[s] = np;
            end
            if (ar[0] == 1 && ar[1] == 1) mprio = 1 - mprio;
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic op(input int s, input logic w, input logic [1:0] i, input logic [7:0] d,
                      output logic [7:0] rd);
        logic ok;
        rq[s] = 1'b1; wr[s] = w; ix[s] = i; wd[s] = d;
        do begin
            @(negedge clk); #1;
            ok = rdy[s];
            rd = rdd[s];
            tick();
        end while (!ok);
        rq[s] = 1'b0;
    endtask

    initial begin
        #400000;
        total++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    initial begin : stim
        logic [7:0] r;
        logic hold [2];
        for (int s = 0; s < 2; s++) begin rq[s] = 0; wr[s] = 0; ix[s] = 0; wd[s] = 0; end
        repeat (3) tick();
        rst = 1'b0;

        // R10 reset state
        op(0, 0, 2'd0, 0, r); chk("R10 ptr A after reset", int'(r), 0);
        op(1, 0, 2'd2, 0, r); chk("R10 out B after reset", int'(r), 0);
        @(negedge clk); #1;
        chk("R10 pend A", int'(pnd[0]), 0); chk("R10 pend B", int'(pnd[1]), 0);
        chk("R11 idle rdata A", int'(rdd[0]), 0); chk("R7 idle ready B", int'(rdy[1]), 1);
        tick();

        // R3 wrap across 255
        op(0, 1, 2'd0, 8'd250, r);
        for (int k = 0; k < 8; k++) op(0, 1, 2'd1, 8'(100 + k), r);
        op(0, 0, 2'd0, 0, r); chk("R3 ptr wrap", int'(r), 2);
        op(1, 1, 2'd0, 8'd250, r);
        for (int k = 0; k < 8; k++) begin
            op(1, 0, 2'd1, 0, r); chk("R1 cross-side read", int'(r), 100 + k);
        end

        // fill the whole array
        op(0, 1, 2'd0, 8'd0, r);
        for (int k = 0; k < 256; k++) op(0, 1, 2'd1, 8'((k * 37 + 5) % 256), r);
        op(0, 0, 2'd0, 0, r); chk("R3 ptr after 256", int'(r), 0);

        // R7 lone array request completes at once
        op(0, 1, 2'd0, 8'd10, r);
        op(1, 1, 2'd0, 8'd20, r);
        rq[0] = 1; wr[0] = 0; ix[0] = 2'd1;
        rq[1] = 1; wr[1] = 0; ix[1] = 2'd1;
        @(negedge clk); #1;
        chk("R9 first contention A", int'(rdy[0]), 1);
        chk("R9 first contention B stalled", int'(rdy[1]), 0);
        chk("R1 A reads 10", int'(rdd[0]), 119);
        tick(); rq[0] = 0;
        @(negedge clk); #1;
        chk("R8 B served next", int'(rdy[1]), 1);
        chk("R1 B reads 20", int'(rdd[1]), 233);
        tick();
        rq[0] = 1;
        @(negedge clk); #1;
        chk("R9 second contention B", int'(rdy[1]), 1);
        chk("R9 second contention A stalled", int'(rdy[0]), 0);
        chk("R1 B reads 21", int'(rdd[1]), 14);
        tick(); rq[1] = 0;
        @(negedge clk); #1;
        chk("R8 A served next", int'(rdy[0]), 1);
        chk("R1 A reads 11", int'(rdd[0]), 156);
        chk("R7 lone request", int'(rdy[0]), 1);
        tick(); rq[0] = 0;

        // messages
        op(0, 1, 2'd2, 8'h5A, r);
        @(negedge clk); #1; chk("R4 pend B set", int'(pnd[1]), 1); tick();
        op(1, 0, 2'd3, 0, r); chk("R4 B gets msg", int'(r), 8'h5A);
        @(negedge clk); #1; chk("R5 pend B cleared", int'(pnd[1]), 0); tick();
        op(0, 0, 2'd2, 0, r); chk("R6 A own msg", int'(r), 8'h5A);
        rq[0] = 1; wr[0] = 1; ix[0] = 2'd2; wd[0] = 8'h33;
        rq[1] = 1; wr[1] = 0; ix[1] = 2'd3;
        @(negedge clk); #1; chk("R5 read before post", int'(rdd[1]), 8'h5A);
        tick(); rq[0] = 0; rq[1] = 0;
        @(negedge clk); #1; chk("R5 post wins over clear", int'(pnd[1]), 1); tick();
        op(1, 0, 2'd3, 0, r); chk("R4 B gets new msg", int'(r), 8'h33);

        // mid-run reset
        rst = 1'b1; repeat (2) tick(); rst = 1'b0;
        op(0, 0, 2'd0, 0, r); chk("R10 ptr A cleared", int'(r), 0);
        op(0, 0, 2'd2, 0, r); chk("R10 out A cleared", int'(r), 0);
        op(1, 0, 2'd3, 0, r); chk("R10 in B cleared", int'(r), 0);

        // random traffic, stalled requests re-presented
        hold[0] = 0; hold[1] = 0;
        for (int c = 0; c < 4000; c++) begin
            for (int s = 0; s < 2; s++) begin
                if (!hold[s]) begin
                    rq[s] = ($urandom % 4) != 0;
                    wr[s] = ($urandom % 2) != 0;
                    ix[s] = 2'($urandom % 4);
                    if (($urandom % 3) != 0) ix[s] = 2'd1;
                    wd[s] = 8'($urandom);
                end
            end
            @(negedge clk); #1;
            for (int s = 0; s < 2; s++) hold[s] = rq[s] && !rdy[s];
            tick();
        end
        rq[0] = 0; rq[1] = 0;
        tick();
        summary();
    end
endmodule